// File: doc/BRIEF.md
# Mixed Strict-Priority and Deficit-Weighted Egress Arbiter

This block picks one egress queue per decision for a single port that has eight queues. A split count N, set at run time, divides the queues into two groups. Queues with an index of N or above are served in strict priority, and the highest index is preferred. Queues below N share the rest of the bandwidth by deficit weighted round robin. A strict requester always beats every member of the weighted group.

Each weighted queue has a running balance. It also has a 5-bit cost that acts as an inverse weight, so a smaller cost gives a larger share. When a weighted queue wins, its balance grows by (cost+1) × frame length. The next weighted winner is the requester with the lowest balance. The result leaves the block as a registered grant on a valid/ready stream. When the downstream stalls, the grant is held and no new decision is made.

Top module: `egress_mix_arb`

## Requirements
- R1: After reset, `gnt_valid_o` is 0, and all balances and the stored split count are 0.
- R2: The effective split is E = min(`dwrr_cnt_i`, NUM_IN). If any input with an index of E or above requests, the highest such index is granted, and no balance changes.
- R3: When `dwrr_cnt_i` is 0, every input is strict, so the highest requesting index always wins.
- R4: When no strict input requests, the weighted requester (index below E) with the lowest balance is granted. On equal balances the higher index wins.
- R5: A weighted grant adds (cost+1) × length of the winner to the winner's balance. The cost is `cost_i[5i+4:5i]` and the length is `frm_len_i[LEN_W*i +: LEN_W]`.
- R6: If that addition would exceed 2^BAL_W − 1, the winner's balance before the addition is first subtracted from every balance, clamping at 0. The winner's balance then becomes exactly its charge.
- R7: In any cycle where `dwrr_cnt_i` differs from the value it had in the previous cycle, all balances are cleared before that cycle's decision.
- R8: A decision is made at a clock edge where `gnt_valid_o` is low or `gnt_ready_i` is high. If any request is present, `gnt_valid_o` is 1 after that edge with the winner; otherwise `gnt_valid_o` is 0.
- R9: While `gnt_valid_o` is 1 and `gnt_ready_i` is 0, the grant index stays the same and no balance changes. Request changes during that time have no effect.
- R10: While `gnt_valid_o` is 1, `gnt_onehot_o` has exactly one bit set, at position `gnt_idx_o`.
- R11: A `dwrr_cnt_i` above NUM_IN behaves as NUM_IN, so all inputs are then weighted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_IN | Per-queue request flags |
| frm_len_i | input | NUM_IN*LEN_W | Per-queue head frame length |
| cost_i | input | NUM_IN*COST_W | Per-queue weighted cost |
| dwrr_cnt_i | input | CNT_W | Number of low-index queues in the weighted group |
| gnt_valid_o | output | 1 | Grant valid |
| gnt_ready_i | input | 1 | Downstream accepts the grant |
| gnt_onehot_o | output | NUM_IN | One-hot granted queue |
| gnt_idx_o | output | IDX_W | Granted queue index |

## Verification
The bench builds the block with NUM_IN=4, LEN_W=4 and BAL_W=10. With these values every split count (0 to 7, including the clamped values) can be swept against all 16 request patterns. The small balance width also means the normalising subtraction happens after only a few heavy grants. A bench model tracks the balances arithmetically, so tie-breaking, charging, clearing on a count change and stall behaviour are all compared grant by grant.

// File: rtl/egress_arb_pkg.sv
package egress_arb_pkg;
  // Charge for one weighted grant: (cost + 1) * length.
  function automatic int unsigned grant_charge(int unsigned cost, int unsigned len);
    return (cost + 1) * len;
  endfunction
endpackage

// File: rtl/egress_arb_strict.sv
module egress_arb_strict #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  // Ascending scan: the last requester seen is the highest index.
  always_comb begin
    any    = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        any    = 1'b1;
        idx    = IW'(i);
        onehot = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/egress_arb_dwrr.sv
module egress_arb_dwrr #(
  parameter int N     = 8,
  parameter int BAL_W = 20,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       req,
  input  logic [N*BAL_W-1:0] bal,
  output logic               any,
  output logic [IW-1:0]      idx,
  output logic [N-1:0]       onehot
);
  logic [BAL_W-1:0] best;
  // Minimum search; "<=" on an ascending scan breaks ties toward higher index.
  always_comb begin
    any    = 1'b0;
    idx    = '0;
    onehot = '0;
    best   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!any || bal[i*BAL_W +: BAL_W] <= best)) begin
        any    = 1'b1;
        best   = bal[i*BAL_W +: BAL_W];
        idx    = IW'(i);
        onehot = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/egress_arb_bank.sv
module egress_arb_bank #(
  parameter int N     = 8,
  parameter int BAL_W = 20,
  parameter int CHG_W = 20,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               upd,
  input  logic [IW-1:0]      win,
  input  logic [CHG_W-1:0]   charge,
  output logic [N*BAL_W-1:0] bal_eff
);
  logic [N*BAL_W-1:0] bal_q;
  logic [N*BAL_W-1:0] bal_d;
  logic [BAL_W:0]     sum;
  logic [BAL_W-1:0]   base;

  assign bal_eff = clr ? '0 : bal_q;
  assign base    = bal_eff[win*BAL_W +: BAL_W];
  assign sum     = {1'b0, base} + (BAL_W+1)'(charge);

  always_comb begin
    bal_d = bal_eff;
    if (upd) begin
      if (sum[BAL_W]) begin
        for (int i = 0; i < N; i++) begin
          if (bal_eff[i*BAL_W +: BAL_W] >= base)
            bal_d[i*BAL_W +: BAL_W] = bal_eff[i*BAL_W +: BAL_W] - base;
          else
            bal_d[i*BAL_W +: BAL_W] = '0;
        end
        bal_d[win*BAL_W +: BAL_W] = BAL_W'(charge);
      end else begin
        bal_d[win*BAL_W +: BAL_W] = sum[BAL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bal_q <= '0;
    else        bal_q <= bal_d;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> bal_q[$past(win)*BAL_W +: BAL_W] >= BAL_W'($past(charge))); // R6
  AST_CLEAR_ON_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !upd) |=> bal_q == '0); // R7
endmodule

// File: rtl/egress_mix_arb.sv
module egress_mix_arb
  import egress_arb_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int COST_W = 5,
  parameter int LEN_W  = 14,
  parameter int BAL_W  = 20,
  localparam int CNT_W = $clog2(NUM_IN + 1),
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int CHG_W = COST_W + 1 + LEN_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_IN-1:0]        req_i,
  input  logic [NUM_IN*LEN_W-1:0]  frm_len_i,
  input  logic [NUM_IN*COST_W-1:0] cost_i,
  input  logic [CNT_W-1:0]         dwrr_cnt_i,
  output logic                     gnt_valid_o,
  input  logic                     gnt_ready_i,
  output logic [NUM_IN-1:0]        gnt_onehot_o,
  output logic [IDX_W-1:0]         gnt_idx_o
);
  logic [CNT_W-1:0]        cnt_q;
  logic [CNT_W-1:0]        split;
  logic                    clr;
  logic [NUM_IN-1:0]       wmask;
  logic [NUM_IN-1:0]       s_req, w_req;
  logic                    s_any, w_any;
  logic [IDX_W-1:0]        s_idx, w_idx;
  logic [NUM_IN-1:0]       s_oh, w_oh;
  logic [NUM_IN*BAL_W-1:0] bal_eff;
  logic                    fire, upd;
  logic [CHG_W-1:0]        charge;

  assign split = (int'(dwrr_cnt_i) > NUM_IN) ? CNT_W'(NUM_IN) : dwrr_cnt_i;
  assign clr   = dwrr_cnt_i != cnt_q;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_mask
    assign wmask[g] = g < int'(split);
  end

  assign s_req = req_i & ~wmask;
  assign w_req = req_i & wmask;

  egress_arb_strict #(.N(NUM_IN)) u_strict (
    .req(s_req), .any(s_any), .idx(s_idx), .onehot(s_oh)
  );

  egress_arb_dwrr #(.N(NUM_IN), .BAL_W(BAL_W)) u_dwrr (
    .req(w_req), .bal(bal_eff), .any(w_any), .idx(w_idx), .onehot(w_oh)
  );

  assign fire   = !gnt_valid_o || gnt_ready_i;
  assign upd    = fire && !s_any && w_any;
  assign charge = CHG_W'(grant_charge(int'(cost_i[w_idx*COST_W +: COST_W]),
                                      int'(frm_len_i[w_idx*LEN_W +: LEN_W])));

  egress_arb_bank #(.N(NUM_IN), .BAL_W(BAL_W), .CHG_W(CHG_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .win(w_idx),
    .charge(charge), .bal_eff(bal_eff)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      gnt_valid_o  <= 1'b0;
      gnt_idx_o    <= '0;
      gnt_onehot_o <= '0;
    end else begin
      cnt_q <= dwrr_cnt_i;
      if (fire) begin
        gnt_valid_o <= s_any || w_any;
        if (s_any) begin
          gnt_idx_o    <= s_idx;
          gnt_onehot_o <= s_oh;
        end else if (w_any) begin
          gnt_idx_o    <= w_idx;
          gnt_onehot_o <= w_oh;
        end
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && !gnt_ready_i) |=> gnt_valid_o && $stable(gnt_idx_o)); // R9
  AST_ONEHOT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> $onehot(gnt_onehot_o) && gnt_onehot_o[gnt_idx_o]); // R10
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_i == '0) |=> !gnt_valid_o); // R8
  AST_REQ_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_i != '0) |=> gnt_valid_o); // R8
  AST_STRICT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (req_i & ~wmask) != '0) |=> int'(gnt_idx_o) >= int'($past(split))); // R2
endmodule

// File: tb/tb_egress_mix_arb.sv
module tb_egress_mix_arb;
  localparam int NI = 4;
  localparam int CW = 5;
  localparam int LW = 4;
  localparam int BW = 10;
  localparam int KW = $clog2(NI + 1);
  localparam int IW = $clog2(NI);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic [NI-1:0]    req;
  logic [NI*LW-1:0] len_f;
  logic [NI*CW-1:0] cost_f;
  logic [KW-1:0]    cnt;
  logic             rdy;
  logic             gv;
  logic [NI-1:0]    goh;
  logic [IW-1:0]    gidx;

  logic [CW-1:0] cst [NI];
  logic [LW-1:0] ln  [NI];
  always_comb
    for (int i = 0; i < NI; i++) begin
      cost_f[i*CW +: CW] = cst[i];
      len_f[i*LW +: LW]  = ln[i];
    end

  egress_mix_arb #(.NUM_IN(NI), .COST_W(CW), .LEN_W(LW), .BAL_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .frm_len_i(len_f), .cost_i(cost_f),
    .dwrr_cnt_i(cnt), .gnt_valid_o(gv), .gnt_ready_i(rdy),
    .gnt_onehot_o(goh), .gnt_idx_o(gidx)
  );

  int errs = 0, checks = 0;
  int mbal [NI];
  int mcnt;
  bit mv;
  int midx;
  bit [31:0] seed = 32'h1bad_c0de;

  function automatic bit [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic step(string tag);
    int neff, win, chg, sub;
    bit found;
    if (int'(cnt) != mcnt) begin
      for (int j = 0; j < NI; j++) mbal[j] = 0;
      mcnt = int'(cnt);
    end
    if (!mv || rdy) begin
      neff = (int'(cnt) > NI) ? NI : int'(cnt);
      win = -1; found = 0;
      for (int i = NI - 1; i >= neff; i--)
        if (req[i] && !found) begin found = 1; win = i; end
      if (!found) begin
        for (int i = 0; i < neff; i++)
          if (req[i] && (!found || mbal[i] <= mbal[win])) begin found = 1; win = i; end
        if (found) begin
          chg = (int'(cst[win]) + 1) * int'(ln[win]);
          if (mbal[win] + chg > (1 << BW) - 1) begin
            sub = mbal[win];
            for (int j = 0; j < NI; j++) mbal[j] = (mbal[j] >= sub) ? mbal[j] - sub : 0;
            mbal[win] = chg;
          end else mbal[win] += chg;
        end
      end
      mv = found;
      if (found) midx = win;
    end
    @(posedge clk); #1;
    checks++;
    if (gv !== mv || (mv && (int'(gidx) !== midx || goh !== NI'(1) << midx))) begin
      errs++;
      $display("FAIL %s: valid=%0b idx=%0d oh=%b expected valid=%0b idx=%0d",
               tag, gv, gidx, goh, mv, midx);
    end
  endtask

  task automatic rand_costs();
    for (int i = 0; i < NI; i++) begin
      cst[i] = CW'(rnd());
      ln[i]  = LW'(rnd());
    end
  endtask

  initial begin
    #1_000_000;
    errs++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 0; req = '0; cnt = '0; rdy = 1;
    for (int i = 0; i < NI; i++) begin cst[i] = '0; ln[i] = '0; end
    for (int j = 0; j < NI; j++) mbal[j] = 0;
    mcnt = 0; mv = 0; midx = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (gv !== 1'b0) begin errs++; $display("FAIL R1: valid=%0b expected 0", gv); end
    rst_n = 1;
    // R8: idle request pattern produces no grant
    step("R8");
    // Sweep every split count (clamped ones too) against every request pattern
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 16; r++) begin
        cnt = KW'(c); req = NI'(r); rand_costs();
        if (c == 0)                   step("R3");
        else if (c > NI)              step("R11");
        else if ((r >> c) != 0)       step("R2");
        else                          step("R4");
      end
    // Tie-break and charge: split 2, costs 0 and 3, length 1
    cnt = 3; req = '0; step("R7");
    cnt = 2; cst[0] = 0; cst[1] = 3; ln[0] = 1; ln[1] = 1; req = 4'b0011;
    step("R4");
    for (int k = 0; k < 6; k++) step("R5");
    // Heavy charges force normalisation
    cnt = 4; req = 4'b1111;
    for (int i = 0; i < NI; i++) begin cst[i] = 31; ln[i] = 15; end
    for (int k = 0; k < 40; k++) begin ln[k % NI] = LW'(8 + k % 8); step("R6"); end
    // Count change clears balances: next grant is the tie winner
    cnt = 3; req = 4'b0111; step("R7");
    step("R7");
    // Stall holds the grant while requests change
    rdy = 0;
    for (int k = 0; k < 5; k++) begin req = NI'(rnd()) | 4'b0001; step("R9"); end
    rdy = 1; step("R9");
    req = '0; step("R8");
    // Long mixed run with random ready
    for (int k = 0; k < 1500; k++) begin
      if (k % 200 == 0) cnt = KW'(rnd() % 6);
      req = NI'(rnd()); rdy = rnd() % 4 != 0; rand_costs();
      step("R10");
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule